// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable register-array stand-in for a small dynamic RAM. It has 2^ROW_BITS rows and 2^COL_BITS columns, and each cell is DATA_W bits wide. The row half and the column half of a cell address share one narrow address input. The order in which the two active-low strobes fall decides what a cycle does. If the row strobe falls while the column strobe is still high, the cycle opens a row for access. If the row strobe falls while the column strobe is already low, the cycle is a refresh of the row named by an internal counter.

An open row can be accessed in two ways. In page mode, each new fall of the column strobe picks a new column. In static column mode, both strobes stay low and a change on the address pins moves to a new column. A read on real silicon drains the row, so every access also restores it. For that reason an access counts as a refresh of its row. Each row keeps an age count of clock cycles since its last refresh. If any row goes longer than a retention limit without one, a sticky flag is raised. A testbench uses this flag to prove that its refresh schedule covers every row.

All strobes are sampled on the rising edge of a free-running system clock. The edges of the strobes are found by comparing each sample with the one taken a cycle earlier.

Top module: `dram_mux_model`

## Requirements
- R1: A fall of rasN, sampled while casN is high, latches addrIn[ROW_BITS-1:0] as the open row. A later fall of casN latches addrIn[COL_BITS-1:0] as the column. From the following cycle on, dataOut shows the cell at that row and column.
- R2: dataOutEn is 1 only in the cycles after a column has been selected in an open row while both strobes stay low. At all other times dataOutEn is 0 and dataOut is all zeros.
- R3: When weN is low at a column fall, dataIn is written into the selected cell, and the new value appears on dataOut in the following cycle. When weN is high, the cell keeps its old value.
- R4: Page mode: while rasN stays low, each new fall of casN selects, reads or writes a new column of the same open row.
- R5: Static column mode: while both strobes stay low, a change on addrIn selects the new column in the next cycle. If weN is low at that change, dataIn is written to the new cell.
- R6: A fall of rasN sampled while casN is already low is a refresh cycle. No row is opened, dataOutEn stays 0, and no cell contents change.
- R7: Each refresh cycle refreshes the row given by the internal counter and then advances it. The counter wraps from the last row to row 0, so 2^ROW_BITS consecutive refresh cycles cover every row.
- R8: Opening a row, and every column selection within it, reset that row's age to zero.
- R9: ageError rises once any row has gone more than RETENTION clock cycles without a refresh or an access. It then stays high until reset.
- R10: While rstN is low and right after reset, dataOutEn, dataOut and ageError are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe; also acts as the output enable |
| weN | input | 1 | Active-low write enable |
| addrIn | input | ADDR_W (2) | Multiplexed row/column address |
| dataIn | input | DATA_W (4) | Write data |
| dataOut | output | DATA_W (4) | Read data; zero while not enabled |
| dataOutEn | output | 1 | High while read data is being driven |
| ageError | output | 1 | Sticky flag: a row has exceeded its retention time |

## Verification
The bench goes after the strobe-order corner cases. The first is a column strobe that is already low when the row strobe falls. A design that misclassifies this case would open a row and drive data instead of refreshing. The second is page-mode pulses with write enable held high; a model that writes on every column fall would corrupt the cell. The third is address changes with both strobes held low; a design without static column support keeps reading the old column. The bench keeps the block alive for several retention periods using refresh sweeps alone. A counter that does not advance or does not wrap leaves rows stale and raises the error flag. The bench then stops refreshing. A flag that never rises, or that clears by itself, fails the check.

// File: rtl/dram_pkg.sv
package dram_pkg;
  // Single-cycle strobes handed from the strobe decoder to the array and
  // refresh tracker.
  typedef struct packed {
    logic openRow;    // row strobe fell with column strobe high
    logic cbrRefresh; // row strobe fell with column strobe already low
    logic colStrobe;  // a column was selected (page or static move)
    logic colWrite;   // colStrobe with write enable active
  } dramStrobe_t;
endpackage

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic [ADDR_W-1:0]   addrIn,
  output dramStrobe_t         strobe,
  output logic [ROW_BITS-1:0] rowLatch,
  output logic [COL_BITS-1:0] colLatch,
  output logic                colOpen
);
  logic              rasPrevN, casPrevN, rowOpen;
  logic [ADDR_W-1:0] addrPrev;
  logic              rasFall, casFall, staticMove;

  always_comb begin
    rasFall    = rasPrevN & ~rasN;
    casFall    = casPrevN & ~casN & ~rasN & rowOpen;
    staticMove = ~casPrevN & ~casN & ~rasN & colOpen & (addrIn != addrPrev);
    strobe.openRow    = rasFall & casN;
    strobe.cbrRefresh = rasFall & ~casN;
    strobe.colStrobe  = casFall | staticMove;
    strobe.colWrite   = (casFall | staticMove) & ~weN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPrevN <= 1'b1;
      casPrevN <= 1'b1;
      addrPrev <= '0;
      rowOpen  <= 1'b0;
      colOpen  <= 1'b0;
      rowLatch <= '0;
      colLatch <= '0;
    end else begin
      rasPrevN <= rasN;
      casPrevN <= casN;
      addrPrev <= addrIn;
      if (rasN) begin
        rowOpen <= 1'b0;
      end else if (strobe.openRow) begin
        rowOpen  <= 1'b1;
        rowLatch <= addrIn[ROW_BITS-1:0];
      end
      if (rasN || casN) begin
        colOpen <= 1'b0;
      end else if (strobe.colStrobe) begin
        colOpen  <= 1'b1;
        colLatch <= addrIn[COL_BITS-1:0];
      end
    end
  end

  // R2: output enable only follows a cycle where both strobes were low
  a_r2_en_needs_strobes: assert property (@(posedge clk) disable iff (!rstN)
    colOpen |-> ($past(!casN) && $past(!rasN)));

  // R6: refresh cycle never opens a row
  a_r6_cbr_no_open: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cbrRefresh |=> !rowOpen);

  // R6: a refresh never coincides with a column selection
  a_r6_cbr_no_column: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cbrRefresh |-> !strobe.colStrobe);
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array
  import dram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  dramStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [ROW_BITS-1:0] rowLatch,
  input  logic [COL_BITS-1:0] colLatch,
  input  logic                colOpen,
  output logic [DATA_W-1:0]   dataOut
);
  localparam int CELLS = 1 << (ROW_BITS + COL_BITS);

  logic [DATA_W-1:0] cells [CELLS];
  logic [ROW_BITS+COL_BITS-1:0] wrIdx, rdIdx;

  assign wrIdx = {rowLatch, addrIn[COL_BITS-1:0]};
  assign rdIdx = {rowLatch, colLatch};

  // Storage has no reset, like the charge it models.
  always_ff @(posedge clk) begin
    if (strobe.colWrite) cells[wrIdx] <= dataIn;
  end

  assign dataOut = colOpen ? cells[rdIdx] : '0;
endmodule

// File: rtl/dram_refresh_tracker.sv
module dram_refresh_tracker
  import dram_pkg::*;
#(
  parameter int ROW_BITS  = 2,
  parameter int ADDR_W    = 2,
  parameter int RETENTION = 300
) (
  input  logic                clk,
  input  logic                rstN,
  input  dramStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [ROW_BITS-1:0] rowLatch,
  output logic                ageError
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int AGE_W = $clog2(RETENTION + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RETENTION + 1);

  logic [ROW_BITS-1:0] refCnt;
  logic [AGE_W-1:0]    ageQ [ROWS];
  logic [ROWS-1:0]     overdue;
  logic [ROW_BITS-1:0] addrRow;

  assign addrRow = addrIn[ROW_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)                  refCnt <= '0;
    else if (strobe.cbrRefresh) refCnt <= refCnt + 1'b1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit = (strobe.openRow    && addrRow  == ROW_BITS'(r)) ||
                 (strobe.cbrRefresh && refCnt   == ROW_BITS'(r)) ||
                 (strobe.colStrobe  && rowLatch == ROW_BITS'(r));
    always_ff @(posedge clk) begin
      if (!rstN || hit)          ageQ[r] <= '0;
      else if (ageQ[r] != AGE_MAX) ageQ[r] <= ageQ[r] + 1'b1;
    end
    assign overdue[r] = (ageQ[r] == AGE_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ageError <= 1'b0;
    else       ageError <= ageError | (|overdue);
  end

  // R7: counter steps by one (with wrap) on each refresh cycle
  a_r7_counter_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cbrRefresh |=> refCnt == ROW_BITS'($past(refCnt) + 1'b1));

  // R8: opening a row clears its age
  a_r8_open_clears_age: assert property (@(posedge clk) disable iff (!rstN)
    strobe.openRow |=> ageQ[$past(addrRow)] == '0);

  // R9: the error flag is sticky
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ageError |=> ageError);
endmodule

// File: rtl/dram_mux_model.sv
module dram_mux_model
  import dram_pkg::*;
#(
  parameter int ROW_BITS  = 2,
  parameter int COL_BITS  = 2,
  parameter int DATA_W    = 4,
  parameter int RETENTION = 300,
  localparam int ADDR_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              ageError
);
  dramStrobe_t         strobe;
  logic [ROW_BITS-1:0] rowLatch;
  logic [COL_BITS-1:0] colLatch;
  logic                colOpen;

  dram_strobe_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .addrIn(addrIn),
    .strobe(strobe), .rowLatch(rowLatch), .colLatch(colLatch), .colOpen(colOpen)
  );

  dram_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W),
                    .ADDR_W(ADDR_W)) array_i (
    .clk(clk), .strobe(strobe), .addrIn(addrIn), .dataIn(dataIn),
    .rowLatch(rowLatch), .colLatch(colLatch), .colOpen(colOpen), .dataOut(dataOut)
  );

  dram_refresh_tracker #(.ROW_BITS(ROW_BITS), .ADDR_W(ADDR_W),
                         .RETENTION(RETENTION)) tracker_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn),
    .rowLatch(rowLatch), .ageError(ageError)
  );

  assign dataOutEn = colOpen;
endmodule

// File: tb/dram_mux_model_tb_top.sv
`timescale 1ns/1ps
module dram_mux_model_tb_top;
  logic       clk = 1'b0;
  logic       rstN, rasN, casN, weN;
  logic [1:0] addrIn;
  logic [3:0] dataIn, dataOut;
  logic       dataOutEn, ageError;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dram_mux_model dut_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .addrIn(addrIn),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn), .ageError(ageError)
  );

  // {row, col, data}
  localparam logic [7:0] VECS [6] = '{
    {2'd0, 2'd0, 4'hA}, {2'd1, 2'd3, 4'h5}, {2'd2, 2'd1, 4'hC},
    {2'd3, 2'd2, 4'h3}, {2'd0, 2'd3, 4'hF}, {2'd3, 2'd0, 4'h6}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic openRow(input logic [1:0] r);
    addrIn = r; rasN = 1'b0; @(negedge clk);
  endtask

  task automatic closeRow();
    rasN = 1'b1; casN = 1'b1; weN = 1'b1; @(negedge clk);
  endtask

  task automatic casDown(input logic [1:0] c, input logic we, input logic [3:0] d);
    addrIn = c; weN = we; dataIn = d; casN = 1'b0; @(negedge clk);
  endtask

  task automatic casUp();
    casN = 1'b1; weN = 1'b1; @(negedge clk);
  endtask

  task automatic moveCol(input logic [1:0] c, input logic we, input logic [3:0] d);
    addrIn = c; weN = we; dataIn = d; @(negedge clk);
  endtask

  // CAS before RAS, then four RAS pulses: one per row
  task automatic cbrSweep(input string tag);
    casN = 1'b0; @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rasN = 1'b0; @(negedge clk);
      check(tag, {7'd0, dataOutEn}, 8'd0);
      rasN = 1'b1; @(negedge clk);
    end
    casN = 1'b1; @(negedge clk);
  endtask

  task automatic readCell(input logic [1:0] r, input logic [1:0] c,
                          input logic [3:0] exp, input string tag);
    openRow(r);
    casDown(c, 1'b1, 4'h0);
    check(tag, {3'd0, dataOutEn, dataOut}, {4'h1, exp});
    casUp();
    closeRow();
  endtask

  initial begin
    rstN = 1'b0; rasN = 1'b1; casN = 1'b1; weN = 1'b1; addrIn = '0; dataIn = '0;
    idle(3);
    // R10: reset state
    check("R10 reset en", {7'd0, dataOutEn}, 8'd0);
    check("R10 reset data", {4'd0, dataOut}, 8'd0);
    check("R10 reset err", {7'd0, ageError}, 8'd0);
    rstN = 1'b1;
    idle(2);
    check("R10 post-reset err", {7'd0, ageError}, 8'd0);

    // R1/R3: table writes with normal cycles
    for (int i = 0; i < 6; i++) begin
      openRow(VECS[i][7:6]);
      casDown(VECS[i][5:4], 1'b0, VECS[i][3:0]);
      check("R3 write visible", {4'd0, dataOut}, {4'd0, VECS[i][3:0]});
      casUp();
      check("R2 released after CAS", {3'd0, dataOutEn, dataOut}, 8'h00);
      closeRow();
    end
    // R1/R2: table reads
    for (int i = 0; i < 6; i++) readCell(VECS[i][7:6], VECS[i][5:4], VECS[i][3:0], "R1 read back");
    check("R2 idle released", {3'd0, dataOutEn, dataOut}, 8'h00);
    cbrSweep("R6 no drive during refresh");

    // R4: page mode in row 1
    openRow(2'd1);
    casDown(2'd0, 1'b0, 4'h1); casUp();
    casDown(2'd1, 1'b0, 4'h2); casUp();
    casDown(2'd2, 1'b0, 4'h7); casUp();
    casDown(2'd1, 1'b1, 4'hE);
    check("R3 weN high keeps cell", {4'd0, dataOut}, 8'h02); casUp();
    casDown(2'd3, 1'b1, 4'h0);
    check("R4 page read col3", {4'd0, dataOut}, 8'h05); casUp();
    casDown(2'd0, 1'b1, 4'h0);
    check("R4 page read col0", {4'd0, dataOut}, 8'h01); casUp();
    casDown(2'd2, 1'b1, 4'h0);
    check("R4 page read col2", {4'd0, dataOut}, 8'h07); casUp();
    closeRow();

    // R5: static column mode in row 2
    openRow(2'd2);
    casDown(2'd0, 1'b0, 4'h9);
    check("R5 static first", {3'd0, dataOutEn, dataOut}, 8'h19);
    moveCol(2'd1, 1'b0, 4'h4);
    check("R5 static write move", {3'd0, dataOutEn, dataOut}, 8'h14);
    moveCol(2'd2, 1'b0, 4'hB);
    moveCol(2'd0, 1'b1, 4'h0);
    check("R5 static read col0", {4'd0, dataOut}, 8'h09);
    moveCol(2'd2, 1'b1, 4'h0);
    check("R5 static read col2", {4'd0, dataOut}, 8'h0B);
    casUp();
    closeRow();
    readCell(2'd2, 2'd1, 4'h4, "R5 static write stored");

    // R6: CAS low when RAS falls -> refresh, contents intact
    cbrSweep("R6 refresh no drive");
    readCell(2'd0, 2'd3, 4'hF, "R6 refresh keeps data");
    readCell(2'd3, 2'd2, 4'h3, "R6 refresh keeps data");

    // R7: refresh-only operation over several retention periods
    cbrSweep("R7 sweep");
    for (int k = 0; k < 8; k++) begin
      idle(150);
      cbrSweep("R7 sweep");
    end
    check("R7 counter covers all rows", {7'd0, ageError}, 8'd0);

    // R8: accesses alone keep rows fresh
    idle(150);
    for (int r = 0; r < 4; r++) begin
      openRow(r[1:0]); closeRow();
    end
    idle(200);
    check("R8 access resets age", {7'd0, ageError}, 8'd0);
    cbrSweep("R8 sweep");

    // R9: stop refreshing
    idle(330);
    check("R9 overdue flagged", {7'd0, ageError}, 8'd1);
    cbrSweep("R9 sweep");
    idle(5);
    check("R9 flag sticky", {7'd0, ageError}, 8'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule